// File: doc/BRIEF.md
# Read-Capture Delay Calibration Sequencer

This block tunes the sampling point of read data in a quad-SPI master. On a start pulse it first reads the flash identification code with the serial clock on the slow reference rate and the capture delay at zero. That trusted value becomes the golden reference. It then switches the serial clock to the requested target rate and tries every capture delay from zero upwards. Before each attempt it turns the controller off, loads the new delay and turns the controller back on. It then reads the identification code again and compares the result with the golden value.

The run of matching delays forms a window. The sequencer reports the window's first and last good delays, programs the rounded-down midpoint and leaves the controller disabled. If no delay ever matches, or if the command engine flags an error on any read, the run ends at once with a fail pulse. The block remembers the target rate and chip select of its last successful run. A new start request for that same pair finishes immediately and issues no command.

The command engine sits outside the block. It receives a held request with an 8-bit opcode and answers with a one-cycle acknowledge, a 24-bit response and an error flag.

Top module: `capdly_cal_seq`

## Requirements
- R1: The golden read runs with `clk_sel_o` = 0 (slow reference), `dly_o` = 0 and `ctl_en_o` = 1, and uses opcode 0x9F with a 24-bit response.
- R2: Every read after the golden read runs with `clk_sel_o` = 1. The delays go strictly upward from 0 in steps of one. Before each of these reads `ctl_en_o` is low for at least one cycle, and it is high while the request is outstanding.
- R3: `win_lo_o` is the first delay whose response equals the golden value.
- R4: After the low bound is found, the first mismatching delay d ends the sweep: no further read is issued and `win_hi_o` = d − 1.
- R5: If responses still match at delay MAX_DELAY−1, `win_hi_o` = MAX_DELAY−1 and the sweep covers all MAX_DELAY delays.
- R6: If no delay matches, `fail_o` pulses for one cycle, `done_o` does not pulse, and MAX_DELAY+1 reads are issued in total.
- R7: On success, `done_o` pulses once. In that cycle `dly_o` = floor((`win_lo_o` + `win_hi_o`)/2) and `ctl_en_o` = 0.
- R8: A read acknowledged with `cmd_err_i` = 1 ends the run with a `fail_o` pulse and no further read. This applies to the golden read and to any sweep read.
- R9: A start whose `tgt_rate_i` and `cs_i` equal those of the last successful run raises `done_o` in the next cycle and issues no read. A failed run does not change the remembered pair.
- R10: `cmd_req_o` stays high, with `cmd_op_o` unchanged, until the cycle in which `cmd_ack_i` is seen.
- R11: Synchronous reset clears all outputs to 0 and forgets the remembered rate and chip select, so the next start runs a full calibration.
- R12: A window that holds only delay MAX_DELAY−1 gives `win_lo_o` = `win_hi_o` = `dly_o` = MAX_DELAY−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle calibration request |
| tgt_rate_i | input | RATE_W | Code of the requested target serial rate |
| cs_i | input | CS_W | Chip select being calibrated |
| cmd_req_o | output | 1 | Command request, held until acknowledged |
| cmd_op_o | output | 8 | Opcode of the command (identification read) |
| cmd_ack_i | input | 1 | One-cycle command completion |
| cmd_err_i | input | 1 | Command error, valid with `cmd_ack_i` |
| cmd_rsp_i | input | 24 | Response bytes, valid with `cmd_ack_i` |
| clk_sel_o | output | 1 | 0 = slow reference rate, 1 = target rate |
| dly_o | output | $clog2(MAX_DELAY) | Read-capture delay setting |
| ctl_en_o | output | 1 | Controller enable |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| win_lo_o | output | $clog2(MAX_DELAY) | First good delay of the window |
| win_hi_o | output | $clog2(MAX_DELAY) | Last good delay of the window |

## Verification
On every cycle the assertions check the command handshake: the request is held and its opcode does not change. They also check that the controller is enabled while a request is outstanding and that the golden read runs slow with delay zero. At each done pulse they check that `done_o` and `fail_o` never rise together, that the controller is off, that the final delay lies inside the window, and that a known pair gives an immediate done. Only the bench scenarios can show the rest, because it depends on how the flash responder answers. That covers where the window bounds land, when the sweep stops, the number of reads, the order of the delays, how errors abort a run, and how reset and failed runs affect the remembered pair.

// File: rtl/capdly_pkg.sv
package capdly_pkg;
    localparam int          RSP_W   = 24;
    localparam logic [7:0]  OP_RDID = 8'h9F;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_G_EN,
        ST_G_WAIT,
        ST_S_DIS,
        ST_S_SET,
        ST_S_EN,
        ST_S_WAIT,
        ST_FIN
    } cal_st_e;
endpackage

// File: rtl/capdly_cmd.sv
module capdly_cmd
    import capdly_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             gold_cap_i,
    input  logic             cmd_ack_i,
    input  logic             cmd_err_i,
    input  logic [RSP_W-1:0] cmd_rsp_i,
    output logic             cmd_req_o,
    output logic [7:0]       cmd_op_o,
    output logic             fin_o,
    output logic             ferr_o,
    output logic             match_o
);
    typedef struct packed {
        logic             req;
        logic             fin;
        logic             err;
        logic [RSP_W-1:0] rsp;
        logic [RSP_W-1:0] gold;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d     = cmd_q;
        cmd_d.fin = 1'b0;
        if (issue_i) begin
            cmd_d.req = 1'b1;
        end
        if (cmd_q.req && cmd_ack_i) begin
            cmd_d.req = 1'b0;
            cmd_d.fin = 1'b1;
            cmd_d.err = cmd_err_i;
            cmd_d.rsp = cmd_rsp_i;
            if (gold_cap_i && !cmd_err_i) begin
                cmd_d.gold = cmd_rsp_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd_req_o = cmd_q.req;
    assign cmd_op_o  = OP_RDID;
    assign fin_o     = cmd_q.fin;
    assign ferr_o    = cmd_q.err;
    assign match_o   = (cmd_q.rsp == cmd_q.gold);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_op_o))); // R10
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> !cmd_req_o); // R10
    AST_OPCODE: assert property (@(posedge clk) disable iff (rst)
        cmd_req_o |-> (cmd_op_o == 8'h9F)); // R1
endmodule

// File: rtl/capdly_win.sv
module capdly_win #(
    parameter int MAX_DELAY = 16,
    localparam int DW = $clog2(MAX_DELAY)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          upd_i,
    input  logic [DW-1:0] idx_i,
    input  logic          match_i,
    output logic          end_o,
    output logic          ok_o,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] mid_o
);
    localparam logic [DW-1:0] LAST = DW'(MAX_DELAY - 1);

    typedef struct packed {
        logic          found;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } win_t;

    win_t win_d, win_q;
    logic [DW:0] sum;

    always_comb begin
        win_d = win_q;
        if (clr_i) begin
            win_d.found = 1'b0;
        end else if (upd_i) begin
            if (!win_q.found) begin
                if (match_i) begin
                    win_d.found = 1'b1;
                    win_d.lo    = idx_i;
                    win_d.hi    = idx_i;
                end
            end else if (match_i) begin
                win_d.hi = idx_i;
            end else begin
                win_d.hi = idx_i - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign end_o = (idx_i == LAST) || (win_q.found && !match_i);
    assign ok_o  = win_q.found || match_i;
    assign lo_o  = win_q.lo;
    assign hi_o  = win_q.hi;
    assign sum   = {1'b0, win_q.lo} + {1'b0, win_q.hi};
    assign mid_o = sum[DW:1];

    AST_LO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (win_q.found && !clr_i) |=> $stable(lo_o)); // R3
    AST_HI_NOT_BELOW_LO: assert property (@(posedge clk) disable iff (rst)
        win_q.found |-> (hi_o >= lo_o)); // R4
endmodule

// File: rtl/capdly_hist.sv
module capdly_hist #(
    parameter int RATE_W = 8,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_i,
    input  logic [RATE_W-1:0] rec_rate_i,
    input  logic [CS_W-1:0]   rec_cs_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CS_W-1:0]   cs_i,
    output logic              hit_o
);
    typedef struct packed {
        logic              vld;
        logic [RATE_W-1:0] rate;
        logic [CS_W-1:0]   cs;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (rec_i) begin
            h_d.vld  = 1'b1;
            h_d.rate = rec_rate_i;
            h_d.cs   = rec_cs_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign hit_o = h_q.vld && (h_q.rate == rate_i) && (h_q.cs == cs_i);

    AST_REC_HITS: assert property (@(posedge clk) disable iff (rst)
        rec_i |=> (h_q.vld && h_q.rate == $past(rec_rate_i) && h_q.cs == $past(rec_cs_i))); // R9
endmodule

// File: rtl/capdly_cal_seq.sv
module capdly_cal_seq
    import capdly_pkg::*;
#(
    parameter int MAX_DELAY = 16,
    parameter int RATE_W    = 8,
    parameter int CS_W      = 2,
    localparam int DW       = $clog2(MAX_DELAY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] tgt_rate_i,
    input  logic [CS_W-1:0]   cs_i,
    output logic              cmd_req_o,
    output logic [7:0]        cmd_op_o,
    input  logic              cmd_ack_i,
    input  logic              cmd_err_i,
    input  logic [RSP_W-1:0]  cmd_rsp_i,
    output logic              clk_sel_o,
    output logic [DW-1:0]     dly_o,
    output logic              ctl_en_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [DW-1:0]     win_lo_o,
    output logic [DW-1:0]     win_hi_o
);
    typedef struct packed {
        cal_st_e           st;
        logic [DW-1:0]     idx;
        logic              clk_sel;
        logic [DW-1:0]     dly;
        logic              en;
        logic              done;
        logic              fail;
        logic [RATE_W-1:0] rate;
        logic [CS_W-1:0]   cs;
    } seq_t;

    seq_t s_d, s_q;

    logic          issue, wclr, wupd, rec;
    logic          fin, ferr, match;
    logic          wend, wok, hit;
    logic [DW-1:0] mid;

    capdly_cmd u_cmd (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue),
        .gold_cap_i (s_q.st == ST_G_WAIT),
        .cmd_ack_i  (cmd_ack_i),
        .cmd_err_i  (cmd_err_i),
        .cmd_rsp_i  (cmd_rsp_i),
        .cmd_req_o  (cmd_req_o),
        .cmd_op_o   (cmd_op_o),
        .fin_o      (fin),
        .ferr_o     (ferr),
        .match_o    (match)
    );

    capdly_win #(.MAX_DELAY(MAX_DELAY)) u_win (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (wclr),
        .upd_i   (wupd),
        .idx_i   (s_q.idx),
        .match_i (match),
        .end_o   (wend),
        .ok_o    (wok),
        .lo_o    (win_lo_o),
        .hi_o    (win_hi_o),
        .mid_o   (mid)
    );

    capdly_hist #(.RATE_W(RATE_W), .CS_W(CS_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .rec_i      (rec),
        .rec_rate_i (s_q.rate),
        .rec_cs_i   (s_q.cs),
        .rate_i     (tgt_rate_i),
        .cs_i       (cs_i),
        .hit_o      (hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.fail = 1'b0;
        issue    = 1'b0;
        wclr     = 1'b0;
        wupd     = 1'b0;
        rec      = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (hit) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.rate    = tgt_rate_i;
                        s_d.cs      = cs_i;
                        s_d.clk_sel = 1'b0;
                        s_d.dly     = '0;
                        s_d.en      = 1'b0;
                        wclr        = 1'b1;
                        s_d.st      = ST_G_EN;
                    end
                end
            end
            ST_G_EN: begin
                s_d.en = 1'b1;
                issue  = 1'b1;
                s_d.st = ST_G_WAIT;
            end
            ST_G_WAIT: begin
                if (fin) begin
                    if (ferr) begin
                        s_d.fail = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.clk_sel = 1'b1;
                        s_d.idx     = '0;
                        s_d.st      = ST_S_DIS;
                    end
                end
            end
            ST_S_DIS: begin
                s_d.en = 1'b0;
                s_d.st = ST_S_SET;
            end
            ST_S_SET: begin
                s_d.dly = s_q.idx;
                s_d.st  = ST_S_EN;
            end
            ST_S_EN: begin
                s_d.en = 1'b1;
                issue  = 1'b1;
                s_d.st = ST_S_WAIT;
            end
            ST_S_WAIT: begin
                if (fin) begin
                    if (ferr) begin
                        s_d.fail = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        wupd = 1'b1;
                        if (wend) begin
                            if (wok) begin
                                s_d.st = ST_FIN;
                            end else begin
                                s_d.fail = 1'b1;
                                s_d.st   = ST_IDLE;
                            end
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                            s_d.st  = ST_S_DIS;
                        end
                    end
                end
            end
            ST_FIN: begin
                s_d.en   = 1'b0;
                s_d.dly  = mid;
                s_d.done = 1'b1;
                rec      = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_sel_o = s_q.clk_sel;
    assign dly_o     = s_q.dly;
    assign ctl_en_o  = s_q.en;
    assign done_o    = s_q.done;
    assign fail_o    = s_q.fail;

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o)); // R6
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        cmd_req_o |-> ctl_en_o); // R2
    AST_GOLD_SLOW: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_G_WAIT && cmd_req_o) |-> (!clk_sel_o && dly_o == '0)); // R1
    AST_SWEEP_FAST: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_S_WAIT) |-> clk_sel_o); // R2
    AST_DONE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(s_q.st) == ST_FIN) |-> (!ctl_en_o && dly_o >= win_lo_o && dly_o <= win_hi_o)); // R7
    AST_SKIP_NOW: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_IDLE && start_i && hit) |=> (done_o && !cmd_req_o)); // R9
endmodule

// File: tb/sim_capdly_cal_seq.sv
module sim_capdly_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MAXD       = 16;
    localparam int DW         = $clog2(MAXD);
    localparam logic [23:0] ID_OK  = 24'hC2_20_18;
    localparam logic [23:0] ID_BAD = 24'hC2_2F_18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [7:0]        tgt_rate_i = '0;
    logic [1:0]        cs_i = '0;
    logic              cmd_req_o;
    logic [7:0]        cmd_op_o;
    logic              cmd_ack_i = 1'b0;
    logic              cmd_err_i = 1'b0;
    logic [23:0]       cmd_rsp_i = '0;
    logic              clk_sel_o;
    logic [DW-1:0]     dly_o;
    logic              ctl_en_o;
    logic              done_o;
    logic              fail_o;
    logic [DW-1:0]     win_lo_o;
    logic [DW-1:0]     win_hi_o;

    capdly_cal_seq #(.MAX_DELAY(MAXD), .RATE_W(8), .CS_W(2)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .tgt_rate_i(tgt_rate_i), .cs_i(cs_i),
        .cmd_req_o(cmd_req_o), .cmd_op_o(cmd_op_o), .cmd_ack_i(cmd_ack_i),
        .cmd_err_i(cmd_err_i), .cmd_rsp_i(cmd_rsp_i), .clk_sel_o(clk_sel_o),
        .dly_o(dly_o), .ctl_en_o(ctl_en_o), .done_o(done_o), .fail_o(fail_o),
        .win_lo_o(win_lo_o), .win_hi_o(win_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // responder configuration (written by main only)
    int wlo = 0, whi = 0, win_en = 0, err_at = -1, lat = 1;
    // responder state (written by responder only)
    int rd_cnt = 0, bad_gold = 0, bad_sweep = 0, bad_hold = 0;
    int exp_idx = 0, rn = 0, saw_dis = 0;
    logic [23:0] rsp_v;
    logic        err_v;

    always begin
        @(negedge clk);
        if (!ctl_en_o) saw_dis = 1;
        if (cmd_req_o) begin
            rd_cnt = rd_cnt + 1;
            if (cmd_op_o != 8'h9F) bad_gold = bad_gold + 1;
            if (!clk_sel_o) begin
                rn = 0;
                exp_idx = 0;
                if (dly_o != '0 || !ctl_en_o) bad_gold = bad_gold + 1;
                rsp_v = ID_OK;
            end else begin
                rn = rn + 1;
                if (int'(dly_o) != exp_idx || !ctl_en_o || saw_dis == 0) bad_sweep = bad_sweep + 1;
                exp_idx = exp_idx + 1;
                rsp_v = (win_en != 0 && int'(dly_o) >= wlo && int'(dly_o) <= whi) ? ID_OK : ID_BAD;
            end
            err_v = (rn == err_at);
            saw_dis = 0;
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                if (!cmd_req_o) bad_hold = bad_hold + 1;
            end
            cmd_ack_i = 1'b1;
            cmd_rsp_i = rsp_v;
            cmd_err_i = err_v;
            @(negedge clk);
            cmd_ack_i = 1'b0;
            cmd_rsp_i = '0;
            cmd_err_i = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // outcome: 1 = done, 2 = fail
    task automatic run(input int rate, input int cs, output int outc, output int reads);
        int r0;
        int n;
        r0 = rd_cnt;
        outc = 0;
        n = 0;
        @(negedge clk);
        tgt_rate_i = 8'(rate);
        cs_i = 2'(cs);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (outc == 0 && n < 2000) begin
            if (done_o) outc = 1;
            else if (fail_o) outc = 2;
            else begin
                @(negedge clk);
                n++;
            end
        end
        repeat (4) @(negedge clk);
        reads = rd_cnt - r0;
    endtask

    initial begin
        int outc, reads, b0, b1, b2;
        int exp_reads, last_rate, last_cs, mid_prev;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!done_o && !fail_o && !cmd_req_o && !ctl_en_o && !clk_sel_o && dly_o == '0,
            "R11 reset outputs", int'(dly_o), 0);
        rst = 1'b0;

        // sweep over every window position
        for (int lo = 0; lo < MAXD; lo++) begin
            for (int hi = lo; hi < MAXD; hi++) begin
                wlo = lo; whi = hi; win_en = 1; err_at = -1;
                lat = 1 + ((lo + hi) % 3);
                b0 = bad_gold; b1 = bad_sweep; b2 = bad_hold;
                run(lo * MAXD + hi, hi % 4, outc, reads);
                exp_reads = 1 + ((hi == MAXD - 1) ? MAXD : hi + 2);
                chk(outc == 1, "R7 done pulse", outc, 1);
                chk(int'(win_lo_o) == lo, "R3 low bound", int'(win_lo_o), lo);
                if (hi == MAXD - 1)
                    chk(int'(win_hi_o) == hi, "R5 high bound at end", int'(win_hi_o), hi);
                else
                    chk(int'(win_hi_o) == hi, "R4 high bound", int'(win_hi_o), hi);
                chk(reads == exp_reads, "R4 read count", reads, exp_reads);
                chk(int'(dly_o) == (lo + hi) / 2, "R7 midpoint", int'(dly_o), (lo + hi) / 2);
                chk(!ctl_en_o, "R7 controller off", int'(ctl_en_o), 0);
                chk(bad_gold == b0, "R1 golden read conditions", bad_gold - b0, 0);
                chk(bad_sweep == b1, "R2 sweep order", bad_sweep - b1, 0);
                chk(bad_hold == b2, "R10 request hold", bad_hold - b2, 0);
                if (lo == MAXD - 1)
                    chk(int'(win_lo_o) == MAXD - 1 && int'(win_hi_o) == MAXD - 1 && int'(dly_o) == MAXD - 1,
                        "R12 last-step window", int'(dly_o), MAXD - 1);
            end
        end

        // R9: remember last success, then repeat
        wlo = 3; whi = 8; win_en = 1; err_at = -1; lat = 2;
        run(77, 1, outc, reads);
        chk(outc == 1, "R9 base run", outc, 1);
        mid_prev = int'(dly_o);
        last_rate = 77; last_cs = 1;
        run(last_rate, last_cs, outc, reads);
        chk(outc == 1 && reads == 0, "R9 skip no reads", reads, 0);
        chk(int'(dly_o) == mid_prev, "R9 delay kept", int'(dly_o), mid_prev);
        // R9 immediate done: done one cycle after start
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o, "R9 done next cycle", int'(done_o), 1);
        repeat (3) @(negedge clk);

        // R6: no matching delay
        win_en = 0;
        b1 = bad_sweep;
        run(90, 2, outc, reads);
        chk(outc == 2, "R6 fail pulse", outc, 2);
        chk(reads == MAXD + 1, "R6 read count", reads, MAXD + 1);
        chk(bad_sweep == b1, "R2 full sweep order", bad_sweep - b1, 0);

        // R8: error on golden read
        win_en = 1; wlo = 5; whi = 9; err_at = 0;
        run(91, 2, outc, reads);
        chk(outc == 2, "R8 golden error fail", outc, 2);
        chk(reads == 1, "R8 golden error stops", reads, 1);

        // R8: error on the fourth sweep read
        err_at = 4;
        run(92, 3, outc, reads);
        chk(outc == 2, "R8 sweep error fail", outc, 2);
        chk(reads == 5, "R8 sweep error stops", reads, 5);
        err_at = -1;

        // R9: failed runs leave the remembered pair intact
        run(last_rate, last_cs, outc, reads);
        chk(outc == 1 && reads == 0, "R9 history after fail", reads, 0);
        // other chip select runs fully
        run(last_rate, 3, outc, reads);
        chk(reads == 1 + whi + 2, "R9 new chip select full run", reads, 1 + whi + 2);

        // R11: reset forgets history
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!ctl_en_o && dly_o == '0 && !clk_sel_o, "R11 reset clears outputs", int'(dly_o), 0);
        rst = 1'b0;
        run(last_rate, 3, outc, reads);
        chk(outc == 1 && reads == 1 + whi + 2, "R11 full run after reset", reads, 1 + whi + 2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
        $finish;
    end
endmodule